// File: doc/BRIEF.md
# Low-Depth Pixel Expander

This stage sits in a display pipeline in front of the blender. It takes one raw pixel word at a time, together with a format code and a replication control bit, and widens every colour and alpha field to eight bits. The result is one 32-bit ARGB word with alpha in bits 31:24, red in 23:16, green in 15:8 and blue in 7:0. Narrow fields are moved to the top of their byte. The bits left empty below them are either cleared or filled by repeating the field's upper bits, depending on the replication bit.

The same control bit also decides what a one-bit alpha of 1 means: half transparent (0x80) or fully opaque (0xFF). Formats that are already 24 or 32 bits per pixel are not widened. The stage holds one register of storage. Upstream and downstream each use a valid/ready handshake, so the stage can stall without losing a pixel.

Top module: `pix_expand`

## Requirements
- R1: Format code 0 is a 16-bit pixel with red in bits 15:11, green in 10:5 and blue in 4:0. Each field is placed at the top of its output byte.
- R2: When `in_rep` is 0, the low bits of every widened field are zero. For example, RGB pixel 0xFFFF in format 0 gives 0xFFF8FCF8.
- R3: When `in_rep` is 1, the low bits are filled by repeating the field's own bits from the most significant bit downwards, wrapping around as often as needed. A full-scale field therefore gives 0xFF.
- R4: Format code 2 has alpha in bits 15:12, red in 11:8, green in 7:4 and blue in 3:0. Its alpha follows the same zero-fill or replication rule as the colours.
- R5: Format code 1 has a one-bit alpha in bit 15, red in 14:10, green in 9:5 and blue in 4:0. An alpha bit of 0 gives 0x00. An alpha bit of 1 gives 0x80 when `in_rep` is 0 and 0xFF when `in_rep` is 1.
- R6: The formats with no alpha field output alpha 0xFF. These are code 0, code 3 (12 bits: red 11:8, green 7:4, blue 3:0) and code 4 (15 bits: red 14:10, green 9:5, blue 4:0).
- R7: Code 5 passes bits 23:0 through unchanged, with alpha 0xFF. Codes 6 and 7 pass all 32 bits through unchanged. `in_rep` has no effect on codes 5, 6 and 7.
- R8: A pixel accepted on a clock edge (`in_valid` and `in_ready` both high) appears on the output with `out_valid` after that same edge. Pixels leave in the order they arrived. `in_ready` is high whenever the output register is empty or is being read in that cycle.
- R9: While `out_valid` is high and `out_ready` is low, `out_argb` and `out_valid` hold, and `in_ready` is low.
- R10: While `rst_n` is low, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Stage can take a pixel |
| in_pixel | input | 32 | Raw pixel word, right-aligned |
| in_fmt | input | 3 | Format code (see R1 to R7) |
| in_rep | input | 1 | 1 selects replication fill, 0 selects zero fill |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer takes the output word |
| out_argb | output | 32 | Expanded ARGB word |

## Verification
In a single cycle the stage can hand its held word to the consumer and also take a new pixel from upstream. This is where a pipelining mistake would drop or repeat a pixel. Random valid and ready patterns create many such cycles, mixed with stalls of several cycles. A queue of expected words, computed by a bench model of the widening rules, checks every departing word in order. The queue must be empty once the stage has drained.

// File: rtl/pix_expand.sv
module pix_expand (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_pixel,
  input  logic [2:0]  in_fmt,
  input  logic        in_rep,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_argb
);

  function automatic logic [7:0] wide4(input logic [3:0] v, input logic rep);
    return rep ? {v, v} : {v, 4'h0};
  endfunction

  function automatic logic [7:0] wide5(input logic [4:0] v, input logic rep);
    return rep ? {v, v[4:2]} : {v, 3'h0};
  endfunction

  function automatic logic [7:0] wide6(input logic [5:0] v, input logic rep);
    return rep ? {v, v[5:4]} : {v, 2'h0};
  endfunction

  function automatic logic [7:0] wide1(input logic v, input logic rep);
    return v ? (rep ? 8'hFF : 8'h80) : 8'h00;
  endfunction

  logic [31:0] expanded;
  logic [31:0] argb_q;
  logic        valid_q;
  logic        take;

  always_comb begin
    unique case (in_fmt)
      3'd0: expanded = {8'hFF, wide5(in_pixel[15:11], in_rep),
                        wide6(in_pixel[10:5], in_rep), wide5(in_pixel[4:0], in_rep)};
      3'd1: expanded = {wide1(in_pixel[15], in_rep), wide5(in_pixel[14:10], in_rep),
                        wide5(in_pixel[9:5], in_rep), wide5(in_pixel[4:0], in_rep)};
      3'd2: expanded = {wide4(in_pixel[15:12], in_rep), wide4(in_pixel[11:8], in_rep),
                        wide4(in_pixel[7:4], in_rep), wide4(in_pixel[3:0], in_rep)};
      3'd3: expanded = {8'hFF, wide4(in_pixel[11:8], in_rep),
                        wide4(in_pixel[7:4], in_rep), wide4(in_pixel[3:0], in_rep)};
      3'd4: expanded = {8'hFF, wide5(in_pixel[14:10], in_rep),
                        wide5(in_pixel[9:5], in_rep), wide5(in_pixel[4:0], in_rep)};
      3'd5: expanded = {8'hFF, in_pixel[23:0]};
      default: expanded = in_pixel;
    endcase
  end

  assign in_ready  = !valid_q || out_ready;
  assign take      = in_valid && in_ready;
  assign out_valid = valid_q;
  assign out_argb  = argb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      argb_q  <= 32'h0;
    end else begin
      if (take) begin
        valid_q <= 1'b1;
        argb_q  <= expanded;
      end else if (out_ready) begin
        valid_q <= 1'b0;
      end
    end
  end

endmodule

module pix_expand_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [31:0] in_pixel,
  input logic [2:0]  in_fmt,
  input logic        in_rep,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_argb
);

  logic acc;
  assign acc = in_valid && in_ready;

  assert_hold_on_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_argb)));

  assert_ready_when_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  assert_accept_presents_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  assert_half_alpha_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_fmt == 3'd1 && in_pixel[15] && !in_rep) |=> out_argb[31:24] == 8'h80);

  assert_clear_alpha_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_fmt == 3'd1 && !in_pixel[15]) |=> out_argb[31:24] == 8'h00);

  assert_opaque_noalpha_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (in_fmt == 3'd0 || in_fmt == 3'd3 || in_fmt == 3'd4)) |=> out_argb[31:24] == 8'hFF);

  assert_pass_through_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_fmt[2:1] == 2'b11) |=> out_argb == $past(in_pixel));

endmodule

bind pix_expand pix_expand_checker u_pix_expand_checker (.*);

// File: tb/pix_expand_bench.sv
`timescale 1ns/1ps
module pix_expand_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_pixel;
  logic [2:0]  in_fmt;
  logic        in_rep;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_argb;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        prev_stall = 1'b0;
  logic [31:0] held = 32'h0;

  always #2 clk = ~clk;

  pix_expand u_pix_expand (.*);

  function automatic logic [7:0] grow(input logic [7:0] v, input int w, input logic rep);
    logic [7:0] r = 8'h0;
    for (int i = 0; i < 8; i++)
      if (i < w || rep) r[7-i] = v[w-1-(i % w)];
    return r;
  endfunction

  function automatic logic [31:0] model(input logic [31:0] p, input logic [2:0] f, input logic r);
    logic [7:0] a;
    case (f)
      3'd0: return {8'hFF, grow(8'(p[15:11]), 5, r), grow(8'(p[10:5]), 6, r), grow(8'(p[4:0]), 5, r)};
      3'd1: begin
        a = p[15] ? (r ? 8'hFF : 8'h80) : 8'h00;
        return {a, grow(8'(p[14:10]), 5, r), grow(8'(p[9:5]), 5, r), grow(8'(p[4:0]), 5, r)};
      end
      3'd2: return {grow(8'(p[15:12]), 4, r), grow(8'(p[11:8]), 4, r),
                    grow(8'(p[7:4]), 4, r), grow(8'(p[3:0]), 4, r)};
      3'd3: return {8'hFF, grow(8'(p[11:8]), 4, r), grow(8'(p[7:4]), 4, r), grow(8'(p[3:0]), 4, r)};
      3'd4: return {8'hFF, grow(8'(p[14:10]), 5, r), grow(8'(p[9:5]), 5, r), grow(8'(p[4:0]), 5, r)};
      3'd5: return {8'hFF, p[23:0]};
      default: return p;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] f, input logic r);
    case (f)
      3'd0: return r ? "R1/R3" : "R1/R2";
      3'd1: return "R5";
      3'd2: return "R4";
      3'd3, 3'd4: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [31:0] p, input logic [2:0] f,
                      input logic r, input logic rdy);
    @(negedge clk);
    in_valid = v; in_pixel = p; in_fmt = f; in_rep = r; out_ready = rdy;
    #0.5;
    if (prev_stall) begin
      check(32'(out_valid), 32'h1, "R9 valid held");
      check(out_argb, held, "R9 word held");
    end
    if (out_valid && !out_ready) check(32'(in_ready), 32'h0, "R9 ready low");
    if (!out_valid) check(32'(in_ready), 32'h1, "R8 ready when empty");
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) check(out_argb, 32'hX, "R8 unexpected word");
      else check(out_argb, exp_q.pop_front(), tag_q.pop_front());
    end
    if (in_valid && in_ready) begin
      exp_q.push_back(model(p, f, r));
      tag_q.push_back(tag_of(f, r));
    end
    prev_stall = out_valid && !out_ready;
    held = out_argb;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; in_valid = 1'b0; in_pixel = 32'h0; in_fmt = 3'd0; in_rep = 1'b0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    check(32'(out_valid), 32'h0, "R10 out_valid");
    check(32'(in_ready), 32'h1, "R10 in_ready");
    check(model(32'hFFFF, 3'd0, 1'b0), 32'hFFF8FCF8, "R2 model");
    check(model(32'hFFFF, 3'd0, 1'b1), 32'hFFFFFFFF, "R3 model");
    rst_n = 1'b1;

    step(1, 32'h0000FFFF, 3'd0, 0, 1);
    step(1, 32'h0000FFFF, 3'd0, 1, 1);
    step(1, 32'h0000B5A6, 3'd0, 1, 1);
    step(1, 32'h00008000, 3'd1, 0, 1);
    step(1, 32'h00008000, 3'd1, 1, 1);
    step(1, 32'h00007FFF, 3'd1, 1, 1);
    step(1, 32'h00008421, 3'd2, 0, 1);
    step(1, 32'h00008421, 3'd2, 1, 1);
    step(1, 32'h00000ABC, 3'd3, 1, 1);
    step(1, 32'h00004210, 3'd4, 0, 1);
    step(1, 32'hDE123456, 3'd5, 1, 1);
    step(1, 32'hDE123456, 3'd6, 1, 1);
    step(1, 32'h01020304, 3'd7, 0, 1);
    step(1, 32'h0000F0F0, 3'd2, 1, 0);
    step(1, 32'h00001234, 3'd0, 0, 0);
    step(1, 32'h00001234, 3'd0, 0, 0);
    step(1, 32'h00001234, 3'd0, 0, 1);
    step(0, 32'h0, 3'd0, 0, 1);

    for (int n = 0; n < 4000; n++)
      step(($urandom % 10) < 7, $urandom, 3'($urandom % 8), 1'($urandom), ($urandom % 4) != 0);

    repeat (4) step(0, 32'h0, 3'd0, 0, 1);
    check(32'(exp_q.size()), 32'h0, "R8 drained in order");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule